// File: doc/BRIEF.md
# Interlaced Sync and Field Timing Generator

This block produces the horizontal sync, vertical sync and field flag for 525-line and 625-line interlaced video. As timing master it runs a pixel counter and a half-line counter, and it derives all three outputs from them. Horizontal sync starts each line. Vertical sync starts at the beginning of a line for the odd field and at mid-line for the even field.

As timing slave it takes external horizontal and vertical sync. A reference edge of vertical sync, either the leading or the trailing edge, opens a window measured in clocks. If a horizontal sync leading edge falls inside that window, the field flag is loaded with a programmed value. The active edge of the vertical sync input reloads the half-line counter with a programmed value, so the output syncs can be offset from the input syncs. Every sync input passes through a two-clock deglitcher, and the polarity of each sync signal is set on its own.

There is no streamed data at this block's edge. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `sync_field_gen`

## Requirements
- R1: In master mode, hs_out is active for exactly HS_WIDTH clocks starting at each line start. The line length is L525 clocks when cfg_std625=0 and L625 clocks when cfg_std625=1.
- R2: In master mode, vs_out is active for 6 half-lines (3 lines) when cfg_std625=0 and for 5 half-lines (2.5 lines) when cfg_std625=1. A frame lasts N525 or N625 lines.
- R3: In master mode, the odd-field vertical sync leading edge coincides with a horizontal sync leading edge. The even-field vertical sync leading edge falls at mid-line, half a frame later, with hs_out inactive.
- R4: In master mode, the field flag is 0 in the odd field and 1 in the even field. It changes only in the cycle where a vertical sync leading edge appears.
- R5: A sync input is accepted only after it has been active on two consecutive clock edges. A one-clock pulse has no effect.
- R6: In slave mode, a filtered hs_in leading edge at offset o clocks from the reference vertical edge loads the field flag with cfg_fld_val when cfg_win_start <= o <= cfg_win_end. The reference edge is offset 0. A hs_in leading edge outside the window leaves the field flag unchanged.
- R7: cfg_ref_trail=0 selects the vs_in leading edge as the window reference, and cfg_ref_trail=1 selects the trailing edge.
- R8: In slave mode, the filtered vs_in leading edge reloads hl_cnt with cfg_hl_reload. The new value is visible after the third rising clock edge from the clock on which vs_in goes active. In master mode vs_in has no effect on hl_cnt.
- R9: cfg_hs_pol and cfg_vs_pol select the level for their own sync, inputs and outputs alike: 1 means active high and 0 means active low. field_out is the field flag when cfg_fld_inv=0 and its inverse when cfg_fld_inv=1.
- R10: During and right after reset, both counters are 0, hs and vs are active, and the field flag is 0 (odd).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = timing master, 0 = slave |
| cfg_std625 | input | 1 | 0 = 525-line, 1 = 625-line standard |
| cfg_hs_pol | input | 1 | Horizontal sync active level |
| cfg_vs_pol | input | 1 | Vertical sync active level |
| cfg_fld_inv | input | 1 | Invert field output |
| cfg_ref_trail | input | 1 | Window reference: 0 leading, 1 trailing vs edge |
| cfg_fld_val | input | 1 | Field value loaded on a window hit |
| cfg_win_start | input | WIN_W | First clock offset of the window |
| cfg_win_end | input | WIN_W | Last clock offset of the window |
| cfg_hl_reload | input | HL_W | Half-line counter reload value |
| hs_in | input | 1 | External horizontal sync |
| vs_in | input | 1 | External vertical sync |
| hs_out | output | 1 | Generated horizontal sync |
| vs_out | output | 1 | Generated vertical sync |
| field_out | output | 1 | Field flag |
| hl_cnt | output | HL_W | Current half-line count |

## Verification
The bench measures where the even-field vertical sync begins, since a design that counts whole lines would start it at a line boundary, together with a horizontal sync. It also measures the frame period and the vertical sync width in both standards; a design with the wrong half-line count per standard drifts or makes a 3-line pulse in 625 mode. In slave mode the bench places horizontal sync edges exactly on both window bounds, just outside them and against the trailing reference. An off-by-one compare or a swapped edge select then shows up as a wrong field level. One-clock glitches on both sync inputs check that a missing deglitcher would show up as a spurious field load or counter reload.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} sfg_std_e;

  // Map a pin level to "asserted" given its polarity (1 = active high).
  function automatic logic sig_act(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/sfg_deglitch.sv
module sfg_deglitch (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_act,
  output logic act,
  output logic rise,
  output logic fall
);
  logic prev_q, state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      state_q <= 1'b0;
      state_d <= 1'b0;
    end else begin
      prev_q <= raw_act;
      if (raw_act && prev_q)        state_q <= 1'b1;
      else if (!raw_act && !prev_q) state_q <= 1'b0;
      state_d <= state_q;
    end
  end

  assign act  = state_q;
  assign rise = state_q & ~state_d;
  assign fall = ~state_q & state_d;
endmodule

// File: rtl/sfg_timebase.sv
module sfg_timebase #(
  parameter int L525 = 858,
  parameter int L625 = 864,
  parameter int N525 = 525,
  parameter int N625 = 625,
  parameter int H_W  = 10,
  parameter int HL_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            std625,
  input  logic            reload_en,
  input  logic [HL_W-1:0] reload_val,
  output logic [H_W-1:0]  h_cnt,
  output logic [HL_W-1:0] hl_cnt
);
  localparam logic [H_W-1:0]  HEND_A  = H_W'(L525 - 1);
  localparam logic [H_W-1:0]  HEND_B  = H_W'(L625 - 1);
  localparam logic [H_W-1:0]  HMID_A  = H_W'(L525 / 2 - 1);
  localparam logic [H_W-1:0]  HMID_B  = H_W'(L625 / 2 - 1);
  localparam logic [HL_W-1:0] HLEND_A = HL_W'(2 * N525 - 1);
  localparam logic [HL_W-1:0] HLEND_B = HL_W'(2 * N625 - 1);

  logic [H_W-1:0]  h_end, h_mid;
  logic [HL_W-1:0] hl_end;
  logic            h_last, half_step;

  always_comb begin
    h_end     = std625 ? HEND_B  : HEND_A;
    h_mid     = std625 ? HMID_B  : HMID_A;
    hl_end    = std625 ? HLEND_B : HLEND_A;
    h_last    = (h_cnt >= h_end);
    half_step = h_last || (h_cnt == h_mid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt  <= '0;
      hl_cnt <= '0;
    end else begin
      h_cnt <= h_last ? '0 : h_cnt + 1'b1;
      if (reload_en)      hl_cnt <= reload_val;
      else if (half_step) hl_cnt <= (hl_cnt >= hl_end) ? '0 : hl_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfg_field_win.sv
module sfg_field_win #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             hs_rise,
  input  logic [WIN_W-1:0] win_start,
  input  logic [WIN_W-1:0] win_end,
  input  logic             fld_val,
  output logic             field
);
  logic             armed_q;
  logic [WIN_W-1:0] wcnt_q, offset;
  logic             hit;

  always_comb begin
    offset = ref_edge ? '0 : wcnt_q;
    hit    = hs_rise && (ref_edge || armed_q) &&
             (offset >= win_start) && (offset <= win_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wcnt_q  <= '0;
      field   <= 1'b0;
    end else begin
      if (ref_edge) begin
        armed_q <= 1'b1;
        wcnt_q  <= WIN_W'(1);
      end else if (armed_q) begin
        if (wcnt_q >= win_end) armed_q <= 1'b0;
        else                   wcnt_q  <= wcnt_q + 1'b1;
      end
      if (hit) field <= fld_val;
    end
  end
endmodule

// File: rtl/sync_field_gen.sv
module sync_field_gen #(
  parameter int L525     = 858,
  parameter int L625     = 864,
  parameter int N525     = 525,
  parameter int N625     = 625,
  parameter int HS_WIDTH = 63,
  parameter int WIN_W    = 10,
  localparam int H_W     = $clog2((L625 > L525) ? L625 : L525),
  localparam int HL_W    = $clog2(2 * ((N625 > N525) ? N625 : N525))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_std625,
  input  logic             cfg_hs_pol,
  input  logic             cfg_vs_pol,
  input  logic             cfg_fld_inv,
  input  logic             cfg_ref_trail,
  input  logic             cfg_fld_val,
  input  logic [WIN_W-1:0] cfg_win_start,
  input  logic [WIN_W-1:0] cfg_win_end,
  input  logic [HL_W-1:0]  cfg_hl_reload,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic             hs_out,
  output logic             vs_out,
  output logic             field_out,
  output logic [HL_W-1:0]  hl_cnt
);
  import sfg_pkg::*;

  localparam logic [HL_W-1:0] HALF_A = HL_W'(N525);
  localparam logic [HL_W-1:0] HALF_B = HL_W'(N625);
  localparam logic [HL_W-1:0] VW_A   = HL_W'(6);
  localparam logic [HL_W-1:0] VW_B   = HL_W'(5);

  sfg_std_e        std;
  logic [H_W-1:0]  h_cnt;
  logic            hs_f, hs_rise, hs_fall;
  logic            vs_f, vs_rise, vs_fall;
  logic            slave, ref_edge, reload_en, fld_slave;
  logic            hs_act, vs_act, fld_act;
  logic [HL_W-1:0] hl_half, vw;

  assign std   = sfg_std_e'(cfg_std625);
  assign slave = ~cfg_master;

  sfg_deglitch u_hs_flt (
    .clk(clk), .rst_n(rst_n), .raw_act(sig_act(hs_in, cfg_hs_pol)),
    .act(hs_f), .rise(hs_rise), .fall(hs_fall));

  sfg_deglitch u_vs_flt (
    .clk(clk), .rst_n(rst_n), .raw_act(sig_act(vs_in, cfg_vs_pol)),
    .act(vs_f), .rise(vs_rise), .fall(vs_fall));

  assign reload_en = slave & vs_rise;
  assign ref_edge  = slave & (cfg_ref_trail ? vs_fall : vs_rise);

  sfg_timebase #(
    .L525(L525), .L625(L625), .N525(N525), .N625(N625),
    .H_W(H_W), .HL_W(HL_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .std625(std == STD_625),
    .reload_en(reload_en), .reload_val(cfg_hl_reload),
    .h_cnt(h_cnt), .hl_cnt(hl_cnt));

  sfg_field_win #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge),
    .hs_rise(slave & hs_rise), .win_start(cfg_win_start),
    .win_end(cfg_win_end), .fld_val(cfg_fld_val), .field(fld_slave));

  always_comb begin
    hl_half = (std == STD_625) ? HALF_B : HALF_A;
    vw      = (std == STD_625) ? VW_B   : VW_A;
    hs_act  = (h_cnt < H_W'(HS_WIDTH));
    vs_act  = (hl_cnt < vw) || ((hl_cnt >= hl_half) && (hl_cnt < hl_half + vw));
    fld_act = cfg_master ? (hl_cnt >= hl_half) : fld_slave;
  end

  assign hs_out    = cfg_hs_pol ? hs_act : ~hs_act;
  assign vs_out    = cfg_vs_pol ? vs_act : ~vs_act;
  assign field_out = fld_act ^ cfg_fld_inv;
endmodule

// File: rtl/sfg_chk.sv
module sfg_chk #(
  parameter int HL_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            master,
  input logic            hs_act,
  input logic            vs_act,
  input logic            fld_act,
  input logic            vs_in,
  input logic            vs_pol,
  input logic            vs_f,
  input logic            vs_rise,
  input logic [HL_W-1:0] hl_cnt,
  input logic [HL_W-1:0] reload
);
  logic vs_raw_act;
  assign vs_raw_act = vs_pol ? vs_in : ~vs_in;

  // R1: a master horizontal sync lasts at least two clocks
  p_hs_two_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    master && $rose(hs_act) |=> hs_act);

  // R3: odd-field vertical sync starts together with horizontal sync
  p_odd_vs_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    master && $rose(vs_act) && !fld_act |-> $rose(hs_act));

  // R3: even-field vertical sync starts at mid-line
  p_even_vs_midline_r3: assert property (@(posedge clk) disable iff (!rst_n)
    master && $rose(vs_act) && fld_act |-> !hs_act);

  // R4: master field flips only with a vertical sync leading edge
  p_field_with_vs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    master && (fld_act != $past(fld_act)) |-> $rose(vs_act));

  // R5: filtered vs only rises after two active raw samples
  p_deglitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_f) |-> $past(vs_raw_act) && $past(vs_raw_act, 2));

  // R8: slave vs leading edge reloads the half-line counter
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !master && vs_rise |=> hl_cnt == $past(reload));
endmodule

bind sync_field_gen sfg_chk #(.HL_W(HL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(cfg_master),
  .hs_act(hs_act), .vs_act(vs_act), .fld_act(fld_act),
  .vs_in(vs_in), .vs_pol(cfg_vs_pol), .vs_f(vs_f), .vs_rise(vs_rise),
  .hl_cnt(hl_cnt), .reload(cfg_hl_reload));

// File: tb/sync_field_gen_tb.sv
module sync_field_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LA = 20, LB = 28, NA = 525, NB = 625, HSW = 4, WW = 10, HLW = 11;

  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_std625 = 0, cfg_hs_pol = 0, cfg_vs_pol = 0;
  logic cfg_fld_inv = 0, cfg_ref_trail = 0, cfg_fld_val = 0;
  logic [WW-1:0]  cfg_win_start = '0, cfg_win_end = '0;
  logic [HLW-1:0] cfg_hl_reload = '0;
  logic hs_in = 1, vs_in = 1;
  logic hs_out, vs_out, field_out;
  logic [HLW-1:0] hl_cnt;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_field_gen #(.L525(LA), .L625(LB), .N525(NA), .N625(NB),
                   .HS_WIDTH(HSW), .WIN_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_std625(cfg_std625),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_fld_inv(cfg_fld_inv),
    .cfg_ref_trail(cfg_ref_trail), .cfg_fld_val(cfg_fld_val),
    .cfg_win_start(cfg_win_start), .cfg_win_end(cfg_win_end),
    .cfg_hl_reload(cfg_hl_reload), .hs_in(hs_in), .vs_in(vs_in),
    .hs_out(hs_out), .vs_out(vs_out), .field_out(field_out), .hl_cnt(hl_cnt));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic master, input logic std);
    @(negedge clk);
    rst_n = 0; cfg_master = master; cfg_std625 = std;
    hs_in = ~cfg_hs_pol; vs_in = ~cfg_vs_pol;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // R10 and R9: reset levels, then hs polarity flip
  task automatic t_reset();
    cfg_hs_pol = 0; cfg_vs_pol = 0; cfg_fld_inv = 0;
    @(negedge clk); rst_n = 0; cfg_master = 1; cfg_std625 = 0;
    repeat (2) @(negedge clk);
    check("R10 hs_out in reset", hs_out, 0);
    check("R10 vs_out in reset", vs_out, 0);
    check("R10 field_out in reset", field_out, 0);
    check("R10 hl_cnt in reset", hl_cnt, 0);
    cfg_hs_pol = 1;
    #1 check("R9 hs active high", hs_out, 1);
    check("R9 vs unaffected", vs_out, 0);
    cfg_fld_inv = 1;
    #1 check("R9 field inverted", field_out, 1);
    cfg_hs_pol = 0; cfg_fld_inv = 0;
  endtask

  // R1..R4: one frame of master timing
  task automatic t_master(input logic std, input int L, input int N, input int vw);
    int hs_cnt = 0, vs_cnt = 0, even_i = -1, frame_i = -1;
    logic pv = 1, pf = 0;
    do_reset(1'b1, std);
    for (int i = 0; i <= N * L + 2; i++) begin
      logic hsa, vsa, f;
      hsa = !hs_out; vsa = !vs_out; f = field_out;
      if (i < 2 * L && hsa) hs_cnt++;
      if (i == L) check("R1 hs at next line start", hsa, 1);
      if (i < 4 * L && vsa) vs_cnt++;
      if (vsa && !pv) begin
        if (even_i < 0) begin
          even_i = i;
          check("R3 even vs at mid-line, hs idle", hsa, 0);
          check("R4 field even at vs", f, 1);
          check("R4 field odd before vs", pf, 0);
        end else if (frame_i < 0) begin
          frame_i = i;
          check("R3 odd vs with hs", hsa, 1);
          check("R4 field back to odd", f, 0);
        end
      end
      pv = vsa; pf = f;
      @(negedge clk);
    end
    check("R1 hs width over two lines", hs_cnt, 2 * HSW);
    check("R2 vs width", vs_cnt, vw * L / 2);
    check("R3 even vs position", even_i, N * L / 2);
    check("R2 frame length", frame_i, N * L);
  endtask

  // R8: vs_in ignored for hl_cnt in master mode
  task automatic t_master_ignore();
    do_reset(1'b1, 1'b0);
    cfg_hl_reload = 11'd500;
    repeat (30) @(negedge clk);
    vs_in = 0;
    repeat (5) @(negedge clk);
    vs_in = 1;
    repeat (5) @(negedge clk);
    check("R8 master ignores vs_in", hl_cnt, 4);
  endtask

  // R8 reload latency, R5 vs glitch ignored
  task automatic t_reload();
    do_reset(1'b0, 1'b0);
    repeat (7) @(negedge clk);
    cfg_hl_reload = 11'd100;
    vs_in = 0;
    repeat (3) @(posedge clk);
    #1 check("R8 reload value", hl_cnt, 100);
    @(negedge clk); vs_in = 1;
    repeat (10) @(negedge clk);
    cfg_hl_reload = 11'd200;
    vs_in = 0; @(negedge clk); vs_in = 1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (hl_cnt == 11'd200) begin
      n_fail++;
      $display("FAIL R5 vs glitch reloaded: actual %0d expected not 200", hl_cnt);
    end
  endtask

  // R6/R5: hs edge d clocks after vs leading edge
  task automatic shot(input int d, input int hs_len, input logic val,
                      input logic exp, input string req);
    cfg_fld_val = val;
    @(negedge clk); vs_in = 0;
    repeat (d) @(negedge clk);
    hs_in = 0;
    repeat (hs_len) @(negedge clk);
    hs_in = 1;
    repeat (10) @(negedge clk);
    check(req, field_out, exp);
    vs_in = 1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_window();
    do_reset(1'b0, 1'b0);
    cfg_ref_trail = 0; cfg_win_start = 10'd2; cfg_win_end = 10'd5;
    check("R6 slave field reset odd", field_out, 0);
    shot(3, 3, 1'b1, 1'b1, "R6 hs inside window loads field");
    shot(7, 3, 1'b0, 1'b1, "R6 hs after window ignored");
    shot(1, 3, 1'b0, 1'b1, "R6 hs before window ignored");
    shot(3, 1, 1'b0, 1'b1, "R5 one-clock hs glitch ignored");
    shot(2, 3, 1'b0, 1'b0, "R6 hs at window start loads");
    shot(5, 3, 1'b1, 1'b1, "R6 hs at window end loads");
  endtask

  // R7: trailing reference
  task automatic trail_shot(input logic trail, input logic val,
                            input logic exp, input string req);
    cfg_ref_trail = trail; cfg_fld_val = val;
    @(negedge clk); vs_in = 0;
    repeat (10) @(negedge clk);
    vs_in = 1;
    repeat (2) @(negedge clk);
    hs_in = 0;
    repeat (3) @(negedge clk);
    hs_in = 1;
    repeat (10) @(negedge clk);
    check(req, field_out, exp);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_trail();
    do_reset(1'b0, 1'b0);
    cfg_win_start = 10'd1; cfg_win_end = 10'd3;
    trail_shot(1'b1, 1'b1, 1'b1, "R7 trailing reference hit");
    trail_shot(1'b0, 1'b0, 1'b1, "R7 leading reference misses");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_master(1'b0, LA, NA, 6);
    t_master(1'b1, LB, NB, 5);
    t_master_ignore();
    t_reload();
    t_window();
    t_trail();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule